// File: doc/BRIEF.md
# Flash Buffered-Program Command Sequencer

This block is the device-side command state machine that turns a run of bus write cycles into one buffered program operation on a parallel NOR-style memory. A host opens the operation with a setup command. It then writes a word count, then the start address together with the first data word, then the remaining address/data pairs, and finally a confirm command. The sequencer collects the data in an internal write buffer and starts a program engine. While the engine works the sequencer is busy. The engine ends the operation with a done pulse and a fail flag.

The geometry is checked while the words are loaded. A range that would leave its erase block, an oversized misaligned range, an address outside the declared range, a bad count and a wrong confirm all end the operation early. Each failure leaves its own combination of sticky bits in an 8-bit status byte, which the block presents at all times. A low programming voltage refuses the operation at setup. A clear-status command removes all error bits.

Top module: `fbp_seq`

## Requirements
- R1: After reset, `status` reads 80h (bit 7 = ready, every error bit clear) and `pgm_start` is low.
- R2: In idle, a write of E8h with `vpp_low` low opens a load and `status` stays 80h. Any idle write other than E8h and 50h (70h and D0h included) changes nothing and starts no program.
- R3: The first write after E8h is always the count, equal to the number of words minus one. 0070h therefore means 113 words. A count above 511 ends the load with bits 5 and 4 set, so `status` reads B0h.
- R4: The next write gives the start address and buffer word 0. Each later write stores its data at offset (address − start) and must satisfy start ≤ address ≤ start + count. An address outside that range ends the load with `status` B0h.
- R5: After the last word, D0h written to any address in the start address's erase block raises `pgm_start` for exactly one cycle after that write. `pgm_base` then holds the start address and `pgm_last` holds the count. Any other data, or a D0h written to another block, sets bits 7, 5 and 4 (B0h) and starts nothing.
- R6: If the start address's offset within its erase block (low `BLK_AW` bits) plus the count reaches the block size, the load ends at the start write with `status` B0h.
- R7: If the start's low 9 address bits are nonzero, the range crosses a 512-word boundary and the count is 256 or more, the load ends with `status` B0h. A crossing range of at most 256 words is accepted.
- R8: E8h written while `vpp_low` is high sets bits 4 and 3 and leaves the block idle.
- R9: While the engine runs, bit 7 reads 0, and `eng_rdata` returns the buffer word selected by `eng_raddr`.
- R10: While busy, every bus write is ignored. A `pgm_done` pulse returns the block to idle with bit 7 set. If `pgm_fail` is high with it, bit 4 is also set (90h from a clean state).
- R11: Bits 5, 4 and 3 are sticky and are cleared only by 50h written in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | AW | Word address of the write |
| bus_wdata | input | 16 | Write data or command code |
| vpp_low | input | 1 | Programming voltage below the lockout level |
| status | output | 8 | Status byte: 7 ready, 5 sequence error, 4 program error, 3 voltage error |
| pgm_start | output | 1 | One-cycle request to the program engine |
| pgm_base | output | AW | Start address of the buffered range |
| pgm_last | output | BUF_AW | Count (words minus one) of the range |
| eng_raddr | input | BUF_AW | Engine buffer read index |
| eng_rdata | output | 16 | Buffer word at `eng_raddr` (combinational) |
| pgm_done | input | 1 | Engine finished pulse |
| pgm_fail | input | 1 | Engine failure, valid with `pgm_done` |

## Verification
Every write is captured at one rising edge. Its effect on `status`, `pgm_start`, `pgm_base` and `pgm_last` appears right after that edge, so the bench drives each write from a falling edge and checks the outputs at the next falling edge. `eng_rdata` has no register, so the buffer is read back in the busy window a moment after each index change. The end status after a `pgm_done` pulse is checked at the falling edge that follows the pulse. `pgm_start` is checked in the half cycle after the confirm and counted over the whole run, which confirms a single pulse for each accepted confirm.

// File: rtl/fbp_seq.sv
module fbp_seq #(
  parameter int AW     = 24,
  parameter int BLK_AW = 16,
  parameter int BUF_AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic              vpp_low,
  output logic [7:0]        status,
  output logic              pgm_start,
  output logic [AW-1:0]     pgm_base,
  output logic [BUF_AW-1:0] pgm_last,
  input  logic [BUF_AW-1:0] eng_raddr,
  output logic [15:0]       eng_rdata,
  input  logic              pgm_done,
  input  logic              pgm_fail
);
  localparam int BUF_N = 1 << BUF_AW;
  localparam logic [15:0] C_SETUP = 16'h00E8, C_CONF = 16'h00D0, C_CLR = 16'h0050;

  typedef enum logic [2:0] {S_IDLE, S_CNT, S_FIRST, S_DATA, S_CONF, S_BUSY} st_t;
  st_t st;

  logic [BUF_AW-1:0] cnt, left;
  logic [AW-1:0]     base;
  logic              e_seq, e_prg, e_vpp;
  logic [15:0]       mem [BUF_N];

  logic [AW-1:0]     off;
  logic [BLK_AW:0]   sum_b;
  logic [BUF_AW:0]   sum_l;
  logic              in_rng, mis_big, first_ok, cnt_bad, blk_match, mem_we;
  logic [BUF_AW-1:0] mem_idx;

  assign off       = bus_addr - base;
  assign in_rng    = off <= AW'(cnt);
  assign sum_b     = {1'b0, bus_addr[BLK_AW-1:0]} + (BLK_AW+1)'(cnt);
  assign sum_l     = {1'b0, bus_addr[BUF_AW-1:0]} + {1'b0, cnt};
  assign mis_big   = (|bus_addr[BUF_AW-1:0]) && sum_l[BUF_AW] && cnt[BUF_AW-1];
  assign first_ok  = !sum_b[BLK_AW] && !mis_big;
  assign cnt_bad   = bus_wdata >= 16'(BUF_N);
  assign blk_match = bus_addr[AW-1:BLK_AW] == base[AW-1:BLK_AW];
  assign mem_we    = bus_we && ((st == S_FIRST && first_ok) || (st == S_DATA && in_rng));
  assign mem_idx   = (st == S_FIRST) ? '0 : off[BUF_AW-1:0];

  assign status    = {st != S_BUSY, 1'b0, e_seq, e_prg, e_vpp, 3'b000};
  assign pgm_base  = base;
  assign pgm_last  = cnt;
  assign eng_rdata = mem[eng_raddr];

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_idx] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      left <= '0;
      base <= '0;
      e_seq <= 1'b0;
      e_prg <= 1'b0;
      e_vpp <= 1'b0;
      pgm_start <= 1'b0;
    end else begin
      pgm_start <= 1'b0;
      case (st)
        S_IDLE: if (bus_we) begin
          if (bus_wdata == C_SETUP) begin
            if (vpp_low) begin
              e_prg <= 1'b1;
              e_vpp <= 1'b1;
            end else st <= S_CNT;
          end else if (bus_wdata == C_CLR) begin
            e_seq <= 1'b0;
            e_prg <= 1'b0;
            e_vpp <= 1'b0;
          end
        end
        S_CNT: if (bus_we) begin
          if (cnt_bad) begin
            e_seq <= 1'b1;
            e_prg <= 1'b1;
            st <= S_IDLE;
          end else begin
            cnt <= bus_wdata[BUF_AW-1:0];
            st <= S_FIRST;
          end
        end
        S_FIRST: if (bus_we) begin
          if (!first_ok) begin
            e_seq <= 1'b1;
            e_prg <= 1'b1;
            st <= S_IDLE;
          end else begin
            base <= bus_addr;
            left <= cnt;
            st <= (cnt == '0) ? S_CONF : S_DATA;
          end
        end
        S_DATA: if (bus_we) begin
          if (!in_rng) begin
            e_seq <= 1'b1;
            e_prg <= 1'b1;
            st <= S_IDLE;
          end else begin
            left <= left - 1'b1;
            if (left == BUF_AW'(1)) st <= S_CONF;
          end
        end
        S_CONF: if (bus_we) begin
          if (bus_wdata == C_CONF && blk_match) begin
            st <= S_BUSY;
            pgm_start <= 1'b1;
          end else begin
            e_seq <= 1'b1;
            e_prg <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_BUSY: if (pgm_done) begin
          if (pgm_fail) e_prg <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fbp_seq_chk.sv
module fbp_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic [15:0] bus_wdata,
  input logic [7:0]  status,
  input logic        pgm_start,
  input logic        pgm_done
);
  a_r5_start_after_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |-> $past(bus_we && bus_wdata == 16'h00D0));

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |-> !status[7]);

  a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_start |=> !pgm_start);

  a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[7] && !pgm_done) |=> (!status[7] && $stable(status[5:3])));

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[4]) |-> $past(bus_we && bus_wdata == 16'h0050));

  a_r6_seq_with_prog: assert property (@(posedge clk) disable iff (!rst_n)
    status[5] |-> status[4]);

  a_r8_vpp_with_prog: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] |-> status[4]);
endmodule

bind fbp_seq fbp_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .status(status), .pgm_start(pgm_start), .pgm_done(pgm_done)
);

// File: tb/fbp_seq_tb_top.sv
module fbp_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [23:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic        vpp_low = 1'b0;
  logic [7:0]  status;
  logic        pgm_start;
  logic [23:0] pgm_base;
  logic [8:0]  pgm_last;
  logic [8:0]  eng_raddr = '0;
  logic [15:0] eng_rdata;
  logic        pgm_done = 1'b0;
  logic        pgm_fail = 1'b0;

  int checks = 0, fails = 0, starts = 0;
  logic [15:0] exp_buf [512];

  always #5 clk = ~clk;

  fbp_seq dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .vpp_low(vpp_low), .status(status),
    .pgm_start(pgm_start), .pgm_base(pgm_base), .pgm_last(pgm_last),
    .eng_raddr(eng_raddr), .eng_rdata(eng_rdata), .pgm_done(pgm_done),
    .pgm_fail(pgm_fail)
  );

  always @(posedge clk) if (pgm_start) starts++;

  function automatic logic [7:0] sr(input bit rdy, input bit sq, input bit pg, input bit vp);
    return {rdy, 1'b0, sq, pg, vp, 3'b000};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic load(input logic [23:0] st, input int cnt, input bit desc);
    logic [15:0] d;
    wr(st, 16'h00E8);
    wr(st, 16'(cnt));
    d = 16'($urandom); exp_buf[0] = d; wr(st, d);
    for (int i = 1; i <= cnt; i++) begin
      int k = desc ? cnt + 1 - i : i;
      d = 16'($urandom); exp_buf[k] = d;
      wr(st + 24'(k), d);
    end
  endtask

  task automatic prog(input logic [23:0] st, input int cnt, input bit desc, input bit fail,
                      input logic [7:0] busy_sr, input logic [7:0] end_sr, input string tag);
    int s0, bad;
    s0 = starts; bad = 0;
    load(st, cnt, desc);
    chk({tag, " R2 ready while loading"}, status, {1'b1, busy_sr[6:0]});
    wr({st[23:16], 16'($urandom)}, 16'h00D0);
    chk({tag, " R5 start pulse"}, pgm_start, 1);
    chk({tag, " R9 busy status"}, status, busy_sr);
    chk({tag, " R5 base"}, pgm_base, st);
    chk({tag, " R5 last"}, pgm_last, cnt);
    for (int i = 0; i <= cnt; i++) begin
      eng_raddr = 9'(i); #1;
      if (eng_rdata !== exp_buf[i]) bad++;
    end
    chk({tag, " R4 R9 buffer contents"}, bad, 0);
    wr(st, 16'h0050);
    wr(st, 16'h00E8);
    chk({tag, " R10 writes ignored while busy"}, status, busy_sr);
    @(negedge clk); pgm_done = 1'b1; pgm_fail = fail;
    @(negedge clk); pgm_done = 1'b0; pgm_fail = 1'b0;
    chk({tag, " R10 end status"}, status, end_sr);
    chk({tag, " R5 one start"}, starts - s0, 1);
  endtask

  task automatic clear_ok(input string tag);
    wr(24'h0, 16'h0050);
    chk({tag, " R11 clear"}, status, 8'h80);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int s0;
    logic [23:0] st;
    int cnt;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 8'h80);
    chk("R1 reset start", pgm_start, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status after release", status, 8'h80);

    s0 = starts;
    wr(24'h000100, 16'h0070);
    wr(24'h000100, 16'h00D0);
    wr(24'h000100, 16'h1234);
    chk("R2 idle non-commands ignored", status, 8'h80);
    chk("R2 no start from idle", starts - s0, 0);

    prog(24'h010000, 112, 1'b0, 1'b0, 8'h00, 8'h80, "R3 count 70h");
    prog(24'h020000, 0, 1'b0, 1'b0, 8'h00, 8'h80, "R3 single word");
    prog(24'h02FFF8, 7, 1'b1, 1'b0, 8'h00, 8'h80, "R6 block end fit");
    prog(24'h040180, 255, 1'b1, 1'b0, 8'h00, 8'h80, "R7 256 word cross");
    prog(24'h050000, 511, 1'b1, 1'b0, 8'h00, 8'h80, "R7 aligned 512");

    for (int n = 0; n < 16; n++) begin
      if (n % 2 == 0) begin
        st = {8'($urandom), 7'($urandom), 9'h000};
        cnt = int'($urandom % 512);
      end else begin
        st = {8'($urandom), 16'($urandom % 65024)};
        cnt = int'($urandom % 256);
      end
      prog(st, cnt, n[2], 1'b0, 8'h00, 8'h80, "R4 random");
    end

    prog(24'h060000, 9, 1'b0, 1'b1, 8'h00, 8'h90, "R10 engine fail");
    clear_ok("R10");

    s0 = starts;
    load(24'h070010, 5, 1'b0);
    wr(24'h070010, 16'h00D1);
    chk("R5 wrong confirm code", status, 8'hB0);
    chk("R5 no start on wrong code", starts - s0, 0);
    clear_ok("R5a");
    load(24'h070010, 5, 1'b0);
    wr(24'h080010, 16'h00D0);
    chk("R5 confirm to other block", status, 8'hB0);
    chk("R5 no start other block", starts - s0, 0);
    clear_ok("R5b");

    wr(24'h02FFFD, 16'h00E8); wr(24'h02FFFD, 16'd7); wr(24'h02FFFD, 16'hAAAA);
    chk("R6 block crossing", status, 8'hB0);
    clear_ok("R6");

    wr(24'h040100, 16'h00E8); wr(24'h040100, 16'd256); wr(24'h040100, 16'h5555);
    chk("R7 misaligned 257 words", status, 8'hB0);
    clear_ok("R7");

    wr(24'h0, 16'h00E8); wr(24'h0, 16'd512);
    chk("R3 count above 511", status, 8'hB0);
    clear_ok("R3");

    wr(24'h090020, 16'h00E8); wr(24'h090020, 16'd3); wr(24'h090020, 16'h0001);
    wr(24'h090024, 16'h0002);
    chk("R4 address above range", status, 8'hB0);
    clear_ok("R4a");
    wr(24'h090020, 16'h00E8); wr(24'h090020, 16'd3); wr(24'h090020, 16'h0001);
    wr(24'h09001F, 16'h0002);
    chk("R4 address below start", status, 8'hB0);
    clear_ok("R4b");

    vpp_low = 1'b1;
    wr(24'h0A0000, 16'h00E8);
    chk("R8 low voltage setup", status, 8'h98);
    wr(24'h0A0000, 16'h0007);
    chk("R8 stays idle", status, 8'h98);
    vpp_low = 1'b0;
    prog(24'h0A0000, 4, 1'b0, 1'b0, 8'h18, 8'h98, "R11 sticky through program");
    clear_ok("R11");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule